// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This unit gathers the event lines of a flash controller and turns them into interrupt flags that software can read through a small register bus. Six sources feed it: flash device ready, controller ready, ECC decode failure, ECC errors detected, ECC ready and write-protect fault. Each source sets its own flag when it goes from low to high. The flag then stays set until software reads the flag register, and that read clears it. A per-bit enable mask selects which flags drive the single level-high interrupt line. Flags are recorded whether or not they are enabled.

A third register shows the live state of the sources. It also carries a 2-bit corrected-error count, coded as the number of corrected symbols minus one. Reads never clear this register. Its device-ready bit runs a configurable number of cycles behind the input.

The register bus is plain control: one address, one write strobe, one read strobe and write data, with read data that follows the address combinationally. There is no handshake and no back-pressure. Each access completes in the cycle it is presented. A read strobe only matters for its clear-on-read side effect.

Top module: `flash_irq_status`

## Requirements
- R1: While reset is held and right after it, the mask register, the flag register, the live register and `irq_o` are all zero.
- R2: A source sets its flag at the first rising clock edge where the source is sampled high after being sampled low. Flag bits are: 5 device ready, 4 controller ready, 3 decode failure, 2 errors detected, 1 ECC ready, 0 write-protect fault. Bits 7:6 read as 0. A set flag stays set until it is cleared.
- R3: A source held high sets its flag only once. After a clear, the flag stays clear until the source goes low and then high again.
- R4: When `bus_addr_i` = 1, `bus_rdata_o` shows the flags. A clock edge with `bus_rd_i` high and `bus_addr_i` = 1 clears every flag that is not being set at that same edge. Reads at other addresses clear nothing.
- R5: A flag whose source rises at the same edge as a clearing read is set after that edge.
- R6: Flags are recorded whatever the mask holds. With the mask at zero, `irq_o` stays low.
- R7: `irq_o` is high exactly while some flag is set and the mask bit at the same position is 1.
- R8: A write strobe at address 0 loads the mask from `bus_wdata_i[5:0]`, and address 0 reads the mask back. Writes to addresses 1 to 3 change nothing. Address 3 reads as zero.
- R9: Address 2 reads the live register, one cycle behind the inputs. Its bits are: 6 decode failure, 5:4 count field, 3 errors detected, 2 ECC ready, 1 controller ready, 0 device ready. Reads never clear it.
- R10: The device-ready live bit lags its input by DEV_LAG clock edges (default 2). The other live bits lag by one edge.
- R11: The count field equals `err_cnt_i` (symbols minus one) when the errors-detected input was high, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_ready_i | input | 1 | Flash device ready level |
| ctl_ready_i | input | 1 | Controller ready level |
| dec_fail_i | input | 1 | ECC decode failure level |
| dec_err_i | input | 1 | ECC errors detected level |
| ecc_ready_i | input | 1 | ECC ready level |
| wp_fault_i | input | 1 | Write-protect fault level |
| err_cnt_i | input | 2 | Corrected symbols minus one |
| bus_addr_i | input | 2 | Register address: 0 mask, 1 flags, 2 live |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (clear-on-read side effect) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bench targets the edge where a source rises under a clearing read. A design that lets the clear win there drops the event, and the flag reads zero after the edge. It holds sources high across a clear to catch a level-sensitive flag, which would come straight back. It reads the live register to catch reads that clear state they should not touch. With the mask at zero, it checks that a flag is still recorded but `irq_o` stays low. It also checks the device-ready lag cycle by cycle and the count field going to zero when errors-detected is low. A wrong lag or a stale count shows up as a mismatch against the cycle-by-cycle model.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int EVT_N = 6;
  // flag / mask bit positions, decoded by software
  localparam int B_WP    = 0;
  localparam int B_ECC   = 1;
  localparam int B_DERR  = 2;
  localparam int B_DFAIL = 3;
  localparam int B_CTL   = 4;
  localparam int B_DEV   = 5;
  // register addresses
  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_FLAG = 2'd1;
  localparam logic [1:0] A_LIVE = 2'd2;
endpackage

// File: rtl/fis_flag_bank.sv
module fis_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign rise = src_i & ~prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o[i] <= 1'b0;
      else if (rise[i]) flag_o[i] <= 1'b1;
      else if (clr_i)   flag_o[i] <= 1'b0;
    end

    // a rise always lands, even against a clear
    assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> flag_o[i]);
    // clear with no new rise empties the flag
    assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !rise[i]) |=> !flag_o[i]);
    // sticky while not cleared
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[i] && !clr_i) |=> flag_o[i]);
    // held level gives no second rise
    assert_no_retrigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i[i] && $past(src_i[i])) |-> !rise[i]);
  end
endmodule

// File: rtl/fis_live_view.sv
module fis_live_view #(
  parameter int CNT_W   = 2,
  parameter int DEV_LAG = 2,
  localparam int LW     = CNT_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_i,
  input  logic             ctl_i,
  input  logic             ecc_i,
  input  logic             derr_i,
  input  logic             dfail_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LW-1:0]    live_o
);
  logic             dev_late;
  logic             ctl_q, ecc_q, derr_q, dfail_q;
  logic [CNT_W-1:0] cnt_q;

  if (DEV_LAG <= 1) begin : g_lag1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dev_late <= 1'b0;
      else        dev_late <= dev_i;
    end
  end else begin : g_lagn
    logic [DEV_LAG-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[DEV_LAG-2:0], dev_i};
    end
    assign dev_late = chain_q[DEV_LAG-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= 1'b0;
      ecc_q   <= 1'b0;
      derr_q  <= 1'b0;
      dfail_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      ctl_q   <= ctl_i;
      ecc_q   <= ecc_i;
      derr_q  <= derr_i;
      dfail_q <= dfail_i;
      cnt_q   <= derr_i ? cnt_i : '0;
    end
  end

  assign live_o = {dfail_q, cnt_q, derr_q, ecc_q, ctl_q, dev_late};

  // count field only carries a value alongside errors-detected
  assert_cnt_needs_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (live_o[CNT_W+3:4] != '0) |-> live_o[3]);
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status #(
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 2,
  parameter int CNT_W   = 2,
  parameter int DEV_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_ready_i,
  input  logic              ctl_ready_i,
  input  logic              dec_fail_i,
  input  logic              dec_err_i,
  input  logic              ecc_ready_i,
  input  logic              wp_fault_i,
  input  logic [CNT_W-1:0]  err_cnt_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  import fis_pkg::*;
  localparam int LW = CNT_W + 5;

  logic [EVT_N-1:0] src;
  logic [EVT_N-1:0] flags;
  logic [EVT_N-1:0] mask_q;
  logic [LW-1:0]    live;
  logic             sel_mask, sel_flag, sel_live, clr;

  assign src[B_WP]    = wp_fault_i;
  assign src[B_ECC]   = ecc_ready_i;
  assign src[B_DERR]  = dec_err_i;
  assign src[B_DFAIL] = dec_fail_i;
  assign src[B_CTL]   = ctl_ready_i;
  assign src[B_DEV]   = dev_ready_i;

  assign sel_mask = (bus_addr_i == ADDR_W'(A_MASK));
  assign sel_flag = (bus_addr_i == ADDR_W'(A_FLAG));
  assign sel_live = (bus_addr_i == ADDR_W'(A_LIVE));
  assign clr      = bus_rd_i && sel_flag;

  fis_flag_bank #(.N(EVT_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_i(src), .clr_i(clr), .flag_o(flags)
  );

  fis_live_view #(.CNT_W(CNT_W), .DEV_LAG(DEV_LAG)) u_live (
    .clk(clk), .rst_n(rst_n),
    .dev_i(dev_ready_i), .ctl_i(ctl_ready_i), .ecc_i(ecc_ready_i),
    .derr_i(dec_err_i), .dfail_i(dec_fail_i), .cnt_i(err_cnt_i),
    .live_o(live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    mask_q <= '0;
    else if (bus_wr_i && sel_mask) mask_q <= bus_wdata_i[EVT_N-1:0];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_mask)      bus_rdata_o = REG_W'(mask_q);
    else if (sel_flag) bus_rdata_o = REG_W'(flags);
    else if (sel_live) bus_rdata_o = REG_W'(live);
  end

  assign irq_o = |(flags & mask_q);

  // an empty mask never raises the line
  assert_mask_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0));
  // line only up while some flag is held
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags != '0));
  // writes elsewhere leave the mask alone
  assert_mask_only_addr0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !sel_mask) |=> $stable(mask_q));
endmodule

// File: tb/tb_flash_irq_status.sv
`timescale 1ns/1ps
module tb_flash_irq_status;
  localparam int DEV_LAG = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ev = '0;         // bit order as the flag register
  logic [1:0] cnt = '0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  flash_irq_status #(.DEV_LAG(DEV_LAG)) dut (
    .clk(clk), .rst_n(rst_n),
    .dev_ready_i(ev[5]), .ctl_ready_i(ev[4]), .dec_fail_i(ev[3]),
    .dec_err_i(ev[2]), .ecc_ready_i(ev[1]), .wp_fault_i(ev[0]),
    .err_cnt_i(cnt), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // reference model state
  logic [5:0] m_flag = '0, m_prev = '0, m_mask = '0;
  logic [6:0] m_live = '0;
  logic       m_dev_q[$];

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_flag = '0; m_prev = '0; m_mask = '0; m_live = '0;
    m_dev_q = {};
    for (int i = 0; i < DEV_LAG; i++) m_dev_q.push_back(1'b0);
  endtask

  task automatic model_step();
    logic [5:0] rise;
    rise = ev & ~m_prev;
    if (rd && addr == 2'd1) m_flag = '0;
    m_flag = m_flag | rise;
    m_prev = ev;
    if (wr && addr == 2'd0) m_mask = wdata[5:0];
    m_dev_q.push_back(ev[5]);
    void'(m_dev_q.pop_front());
    m_live = {ev[3], (ev[2] ? cnt : 2'b00), ev[2], ev[1], ev[4], m_dev_q[0]};
  endtask

  task automatic compare();
    logic [7:0] exp;
    case (addr)
      2'd0:    exp = {2'b00, m_mask};
      2'd1:    exp = {2'b00, m_flag};
      2'd2:    exp = {1'b0, m_live};
      default: exp = 8'h00;
    endcase
    check({7'd0, irq}, {7'd0, |(m_flag & m_mask)}, "R7 irq model");
    check(rdata, exp, addr == 2'd1 ? "R4 flag model" :
                      addr == 2'd2 ? "R9 live model" : "R8 reg model");
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) tick();
    // R1 reset state across all addresses
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      check(rdata, 8'h00, "R1 reset value");
      check({7'd0, irq}, 8'h00, "R1 irq at reset");
    end
    @(negedge clk) rst_n = 1'b1;
    addr = 2'd1;
    tick();
    check(rdata, 8'h00, "R1 after release");

    // R2 rising edge sets errors-detected flag (bit 2)
    ev = 6'b000100; cnt = 2'd2;
    tick();
    check(rdata, 8'h04, "R2 flag bit2");
    addr = 2'd2; #1;
    check(rdata, 8'h2C & 8'h28 | 8'h28, "R11 count field with errors");

    // R4 clearing read while source stays high
    addr = 2'd1; rd = 1'b1;
    tick();
    check(rdata, 8'h00, "R4 cleared by read");
    rd = 1'b0;
    tick(); tick();
    check(rdata, 8'h00, "R3 no retrigger on held level");

    // R5 rise at the same edge as a clearing read
    ev[0] = 1'b1; rd = 1'b1;
    tick();
    check(rdata, 8'h01, "R5 rise beats clear");
    rd = 1'b0;

    // R6 flag recorded but masked
    tick();
    check({7'd0, irq}, 8'h00, "R6 masked irq low");
    check(rdata, 8'h01, "R6 flag kept while masked");

    // R7 enable the mask bit
    addr = 2'd0; wr = 1'b1; wdata = 8'h01;
    tick();
    wr = 1'b0;
    check({7'd0, irq}, 8'h01, "R7 irq raised");

    // R8 writes to other addresses ignored
    addr = 2'd1; wr = 1'b1; wdata = 8'hFF;
    tick();
    addr = 2'd2; tick();
    wr = 1'b0; addr = 2'd0; #1;
    check(rdata, 8'h01, "R8 mask untouched");
    addr = 2'd1; #1;
    check(rdata, 8'h01, "R8 flags untouched");

    // R10 device-ready lag
    addr = 2'd2; ev[5] = 1'b1;
    tick();
    check({7'd0, rdata[0]}, 8'h00, "R10 dev live still low");
    tick();
    check({7'd0, rdata[0]}, 8'h01, "R10 dev live after lag");

    // R9 read at the live address clears nothing
    rd = 1'b1;
    tick();
    check(rdata, 8'h29, "R9 live layout");
    rd = 1'b0; addr = 2'd1; #1;
    check(rdata, 8'h21, "R9 live read left flags");

    // R11 count field zero without errors-detected
    addr = 2'd2; ev[2] = 1'b0; cnt = 2'd3;
    tick();
    check(rdata, 8'h01, "R11 count zeroed");

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      ev    = 6'($urandom);
      cnt   = 2'($urandom);
      addr  = 2'($urandom);
      wr    = ($urandom % 4) == 0;
      rd    = ($urandom % 3) == 0;
      wdata = 8'($urandom);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule